// File: doc/BRIEF.md
# Peripheral Interrupt Flag Controller

This block holds the interrupt flags and interrupt enables of a parallel interface adapter. It latches event pulses into a 7-bit flag register and masks them with a 7-bit enable register. From these it forms a summary bit and an active-low interrupt request. One flag follows a strobe pin with a selectable active edge. The other six flags are set by single-cycle pulses from neighbouring logic such as timers, the shift unit and the port B handshake. The processor reaches both registers through an address, read and write strobes and 8-bit data.

Each flag has its own ways to clear. Writing a one to a flag position clears that flag. The strobe flag is also cleared by any read or write of the port A data register, which neighbouring decode reports on a single strobe input. The enable register is written as a set/clear mask: bit 7 of the written byte chooses whether the marked enables are set or cleared. Turning an enable off never touches the flag behind it, so software can mask a source and still poll it.

The strobe pin is watched by a small state machine with three named states. `ED_INIT` is entered on reset and holds no level history. `ED_LOW` means the last sampled level was 0, and `ED_HIGH` means it was 1. The transitions are: INIT to LOW or HIGH on the first sampled level, with no event; LOW to HIGH when the pin reads 1, which is an event if the rising edge is selected; HIGH to LOW when the pin reads 0, which is an event if the falling edge is selected. All other cases hold the current state.

Top module: `ifc_irq_ctrl`

## Requirements
- R1: After reset all flags and enables are 0, `irq_n` is 1, and the first pin level sampled after reset never counts as an edge, even if it is high.
- R2: With `edge_rise` = 1, a 0-to-1 change on `strobe_pin` sets flag bit 1 on the next clock. With `edge_rise` = 0, a 1-to-0 change does so. The opposite transition sets nothing.
- R3: A pulse on `porta_access` clears flag bit 1 and leaves the other flags unchanged.
- R4: A write to the flag register (offset 0xD) clears each flag whose data bit 6:0 is 1. Bit 7 of the written byte has no effect, so 0x80 clears nothing and 0x02 clears only flag bit 1.
- R5: A pulse on `evt_in[0]` sets flag bit 0, and a pulse on `evt_in[k]` for k = 1..5 sets flag bit k+1.
- R6: A write to the enable register (offset 0xE) with data bit 7 = 1 sets the enables marked by ones in bits 6:0. With bit 7 = 0 it clears them. Unmarked enables are kept.
- R7: Clearing an enable does not clear the matching flag.
- R8: A read of the flag register returns the flags in bits 6:0, and in bit 7 the OR over bits 6:0 of flags AND enables. A read of the enable register returns 1 in bit 7 and the enables in bits 6:0. With `rd_en` low, or at any other offset, `rd_data` is 0.
- R9: `irq_n` is 0 exactly while at least one flag is set whose enable is also set.
- R10: A set and a clear of the same flag in the same cycle leave the flag set. This holds for the strobe edge against `porta_access` and against a flag-register write.
- R11: Reading either register changes no flag and no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_pin | input | 1 | Edge-sensitive handshake input (already synchronous) |
| edge_rise | input | 1 | Active-edge select: 1 rising, 0 falling |
| porta_access | input | 1 | Pulse on any read or write of the port A data register |
| evt_in | input | 6 | Event pulses from other sources, mapped per R5 |
| addr | input | 4 | Register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data (combinational) |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two functions can land in the same cycle: the active strobe edge sets flag bit 1 while a port A access, or a flag-register write of 0x02, clears it. The bench drives the pin transition and the clearing strobe on the same clock edge, once for each kind of clear and again during a long pseudo-random stretch. A behavioural model gives the set priority, and its expected flag value is compared with a register read and with `irq_n` on every cycle.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
    localparam int unsigned N_FLAGS  = 7;
    localparam int unsigned N_EVT    = N_FLAGS - 1;
    localparam int unsigned DATA_W   = N_FLAGS + 1;
    localparam int unsigned STRB_BIT = 1;

    typedef enum logic [1:0] {
        ED_INIT = 2'd0,
        ED_LOW  = 2'd1,
        ED_HIGH = 2'd2
    } edge_state_t;
endpackage

// File: rtl/ifc_edge_detect.sv
module ifc_edge_detect
    import ifc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic rise_sel,
    output logic hit
);
    edge_state_t st_q, st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ED_INIT;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ED_INIT: st_nx = lvl ? ED_HIGH : ED_LOW;
            ED_LOW:  if (lvl)  st_nx = ED_HIGH;
            ED_HIGH: if (!lvl) st_nx = ED_LOW;
            default: st_nx = ED_INIT;
        endcase
    end

    always_comb begin
        hit = 1'b0;
        unique case (st_q)
            ED_INIT: hit = 1'b0;
            ED_LOW:  hit = lvl & rise_sel;
            ED_HIGH: hit = ~lvl & ~rise_sel;
            default: hit = 1'b0;
        endcase
    end

    // R1: the cycle after reset carries no level history, so no event
    a_r1_no_first_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ED_INIT) |-> !hit);
endmodule

// File: rtl/ifc_flag_bank.sv
module ifc_flag_bank #(
    parameter int unsigned N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] flags_q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)          flags_q[i] <= 1'b0;
            else if (set_vec[i]) flags_q[i] <= 1'b1;
            else if (clr_vec[i]) flags_q[i] <= 1'b0;
        end

        // R10: a set always lands, whatever clear comes with it
        a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> flags_q[i]);
        // R7 / R11: with no clear of its own, a set flag stays set
        a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[i] && !clr_vec[i]) |=> flags_q[i]);
    end
endmodule

// File: rtl/ifc_enable_bank.sv
module ifc_enable_bank #(
    parameter int unsigned N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic [N:0]   wdata,
    output logic [N-1:0] en_q
);
    logic set_mode;
    assign set_mode = wdata[N];

    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_hit)
            en_q <= set_mode ? (en_q | wdata[N-1:0]) : (en_q & ~wdata[N-1:0]);
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R6: set-mode write marks the bit
        a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit && wdata[N] && wdata[i]) |=> en_q[i]);
        // R6: clear-mode write drops the bit
        a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit && !wdata[N] && wdata[i]) |=> !en_q[i]);
        // R6: unmarked bits keep their value
        a_r6_keep: assert property (@(posedge clk) disable iff (!rst_n)
            (!(wr_hit && wdata[i])) |=> $stable(en_q[i]));
    end
endmodule

// File: rtl/ifc_irq_ctrl.sv
module ifc_irq_ctrl
    import ifc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] FLAG_OFS = 4'hD,
    parameter logic [ADDR_W-1:0] EN_OFS   = 4'hE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_pin,
    input  logic              edge_rise,
    input  logic              porta_access,
    input  logic [N_EVT-1:0]  evt_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_n
);
    logic               strb_hit;
    logic [N_FLAGS-1:0] set_vec, clr_vec, flags, enables;
    logic               pending, wr_flag, wr_en_reg;

    ifc_edge_detect u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (strobe_pin),
        .rise_sel (edge_rise),
        .hit      (strb_hit)
    );

    assign set_vec = {evt_in[N_EVT-1:1], strb_hit, evt_in[0]};

    assign wr_flag   = wr_en && (addr == FLAG_OFS);
    assign wr_en_reg = wr_en && (addr == EN_OFS);

    always_comb begin
        clr_vec = wr_flag ? wr_data[N_FLAGS-1:0] : '0;
        clr_vec[STRB_BIT] = clr_vec[STRB_BIT] | porta_access;
    end

    ifc_flag_bank #(.N(N_FLAGS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags_q (flags)
    );

    ifc_enable_bank #(.N(N_FLAGS)) u_enables (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_en_reg),
        .wdata  (wr_data),
        .en_q   (enables)
    );

    assign pending = |(flags & enables);
    assign irq_n   = ~pending;

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (addr == FLAG_OFS)    rd_data = {pending, flags};
            else if (addr == EN_OFS) rd_data = {1'b1, enables};
        end
    end

    // R3: a port A access with no coincident edge leaves the strobe flag clear
    a_r3_porta_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (porta_access && !strb_hit) |=> !flags[STRB_BIT]);
    // R2: a detected edge is latched into flag bit 1
    a_r2_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
        strb_hit |=> flags[STRB_BIT]);
    // R9 / R8: summary bit on the read path agrees with the request pin
    a_r9_irq_matches_summary: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == FLAG_OFS) |-> (rd_data[DATA_W-1] == !irq_n));
    // R8: enable read always shows bit 7 high
    a_r8_enable_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == EN_OFS) |-> rd_data[DATA_W-1]);
endmodule

// File: tb/sim_ifc_irq_ctrl.sv
module sim_ifc_irq_ctrl;
    localparam logic [3:0] A_FLAG = 4'hD;
    localparam logic [3:0] A_EN   = 4'hE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe_pin = 1'b0;
    logic       edge_rise = 1'b1;
    logic       porta_access = 1'b0;
    logic [5:0] evt_in = '0;
    logic [3:0] addr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_n;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    // behavioural reference state
    int  ref_flags = 0;
    int  ref_en = 0;
    bit  ref_prev = 0;
    bit  ref_seen = 0;

    always #10 clk = ~clk;

    ifc_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .strobe_pin(strobe_pin), .edge_rise(edge_rise),
        .porta_access(porta_access), .evt_in(evt_in), .addr(addr), .rd_en(rd_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            ref_flags = 0; ref_en = 0; ref_seen = 0; ref_prev = 0;
        end else begin
            int setm, clrm;
            bit ev;
            ev = 0;
            if (ref_seen) begin
                if (edge_rise && !ref_prev && strobe_pin) ev = 1;
                if (!edge_rise && ref_prev && !strobe_pin) ev = 1;
            end
            ref_prev = strobe_pin;
            ref_seen = 1;
            setm = (evt_in[0] ? 1 : 0) | (ev ? 2 : 0) | ((int'(evt_in) >> 1) << 2);
            clrm = 0;
            if (wr_en && addr == A_FLAG) clrm = int'(wr_data[6:0]);
            if (porta_access) clrm = clrm | 2;
            if (wr_en && addr == A_EN) begin
                if (wr_data[7]) ref_en = ref_en | int'(wr_data[6:0]);
                else            ref_en = ref_en & ~int'(wr_data[6:0]);
            end
            ref_flags = (setm | (ref_flags & ~clrm)) & 8'h7F;
        end
    end

    function automatic int exp_read(logic [3:0] a);
        if (a == A_FLAG) return (((ref_flags & ref_en) != 0) ? 8'h80 : 0) | ref_flags;
        if (a == A_EN)   return 8'h80 | ref_en;
        return 0;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // R9 compared on every clock, a quarter period after the edge
    always @(posedge clk) begin
        #5;
        if (rst_n && !finished)
            chk(irq_n == ((ref_flags & ref_en) == 0), "R9 irq_n", irq_n,
                (ref_flags & ref_en) == 0);
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(logic [3:0] a, string tag);
        addr = a; rd_en = 1'b1;
        #2;
        chk(rd_data == 8'(exp_read(a)), tag, rd_data, exp_read(a));
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_lit(logic [3:0] a, logic [7:0] e, string tag);
        addr = a; rd_en = 1'b1;
        #2;
        chk(rd_data == e, tag, rd_data, e);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            bad++;
            checks++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        strobe_pin = 1'b1;              // high through reset: R1 first level
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        rd_lit(A_FLAG, 8'h00, "R1 flags after reset");
        rd_lit(A_EN,   8'h80, "R1 enables after reset");
        chk(irq_n == 1'b1, "R1 irq_n after reset", irq_n, 1);

        // R2 rising edge
        strobe_pin = 1'b0; idle(1);
        strobe_pin = 1'b1; idle(1);
        rd_lit(A_FLAG, 8'h02, "R2 rising edge sets flag1");
        // R3 port access clears only flag1
        evt_in = 6'b000001; idle(1); evt_in = '0;
        porta_access = 1'b1; idle(1); porta_access = 1'b0;
        rd_lit(A_FLAG, 8'h01, "R3 port access clears flag1 only");
        wr(A_FLAG, 8'h01);
        // R2 falling edge select; rising ignored
        edge_rise = 1'b0;
        strobe_pin = 1'b0; idle(1);
        rd_lit(A_FLAG, 8'h02, "R2 falling edge sets flag1");
        wr(A_FLAG, 8'h02);
        strobe_pin = 1'b1; idle(1);
        rd_lit(A_FLAG, 8'h00, "R2 rising edge ignored when falling selected");
        edge_rise = 1'b1;

        // R5 event mapping
        evt_in = 6'b100000; idle(1); evt_in = '0;
        rd_lit(A_FLAG, 8'h40, "R5 evt_in[5] sets flag6");
        evt_in = 6'b011110; idle(1); evt_in = '0;
        rd_lit(A_FLAG, 8'h7C, "R5 evt_in[4:1] set flags 5..2");

        // R4 flag write
        wr(A_FLAG, 8'h80);
        rd_lit(A_FLAG, 8'h7C, "R4 bit7 write clears nothing");
        wr(A_FLAG, 8'h7F);
        strobe_pin = 1'b0; idle(1); strobe_pin = 1'b1; idle(1);
        evt_in = 6'b100000; idle(1); evt_in = '0;
        wr(A_FLAG, 8'h02);
        rd_lit(A_FLAG, 8'h40, "R4 0x02 clears only flag1");
        wr(A_FLAG, 8'h40);

        // R6 / R8 / R9 enable handling
        strobe_pin = 1'b0; idle(1); strobe_pin = 1'b1; idle(1);
        wr(A_EN, 8'h82);
        rd_lit(A_EN, 8'h82, "R6 0x82 enables flag1");
        rd_lit(A_FLAG, 8'h82, "R8 summary bit set");
        chk(irq_n == 1'b0, "R9 irq asserted", irq_n, 0);
        wr(A_EN, 8'h90);
        rd_lit(A_EN, 8'h92, "R6 set keeps other enables");
        wr(A_EN, 8'h02);
        rd_lit(A_EN, 8'h90, "R6 clear drops only marked enable");
        rd_lit(A_FLAG, 8'h02, "R7 flag kept after disable, R8 summary low");
        chk(irq_n == 1'b1, "R9 irq released", irq_n, 1);
        rd_lit(A_FLAG, 8'h02, "R11 reading flags leaves them");
        rd_lit(A_EN, 8'h90, "R11 reading enables leaves them");
        rd_lit(4'h3, 8'h00, "R8 other offset reads 0");
        wr(A_EN, 8'h10);
        wr(A_FLAG, 8'h7F);

        // R10 coincident set and clear
        strobe_pin = 1'b0; idle(1);
        strobe_pin = 1'b1; porta_access = 1'b1; idle(1); porta_access = 1'b0;
        rd_lit(A_FLAG, 8'h02, "R10 edge wins over port access");
        wr(A_FLAG, 8'h02);
        strobe_pin = 1'b0; idle(1);
        strobe_pin = 1'b1; addr = A_FLAG; wr_data = 8'h02; wr_en = 1'b1;
        idle(1); wr_en = 1'b0;
        rd_lit(A_FLAG, 8'h02, "R10 edge wins over flag write");

        // pseudo-random stretch against the model
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            strobe_pin   = r[0];
            edge_rise    = (r[31:28] == 4'h0) ? ~edge_rise : edge_rise;
            porta_access = (r[3:1] == 3'd0);
            evt_in       = (r[7:4] == 4'd0) ? r[13:8] : 6'd0;
            if (r[16:14] == 3'd0) begin
                addr = r[17] ? A_EN : A_FLAG; wr_data = r[25:18]; wr_en = 1'b1;
                idle(1); wr_en = 1'b0; porta_access = 1'b0; evt_in = '0;
            end else if (r[16:14] == 3'd1) begin
                porta_access = 1'b0; evt_in = '0;
                rd(r[17] ? A_EN : A_FLAG, "R8 R10 random read");
            end else begin
                idle(1);
            end
        end
        porta_access = 1'b0; evt_in = '0;
        rd(A_FLAG, "R10 final flags");
        rd(A_EN, "R6 final enables");

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule